// File: doc/BRIEF.md
# APS K1/K2 Persistence Filter

This block qualifies the automatic protection switching signalling that arrives in the line overhead of every received frame. Once per frame, an upstream overhead extractor presents the K1 byte and the upper nibble of K2 with a one-cycle strobe. The block does not accept a value the first time it appears. Each field must repeat unchanged over a run of consecutive frames before it is copied into the accepted-value outputs. K1 uses a fixed run length of three frames. The run length for the K2 nibble comes from a 4-bit configuration input.

Each change of an accepted value raises a sticky delta bit. A separate watchdog raises a third delta bit when K1 keeps changing and never settles. Software clears a delta bit by writing a 1 to it. A per-bit mask keeps a delta out of the active-low interrupt, but the masked delta bit still sets.

Top module: `aps_filter_top`

## Requirements
- R1: The K1 byte is accepted on the clock edge that samples the third consecutive strobed frame carrying the same K1 value. `k1_acc` shows the value after that edge.
- R2: The K2 nibble is accepted on the edge that samples the Nth consecutive strobed frame with an equal nibble, where N is `k2_need`. A `k2_need` of 0 acts as 1. Runs longer than 15 count as 15.
- R3: A strobed frame that differs from the previous strobed frame restarts that field's run at 1. Cycles without `frame_vld` neither extend nor break a run, and they leave the accepted values unchanged.
- R4: After reset, `k1_acc` and `k2_acc` are zero, `dlt` is 000, `k1_unstable` is 0 and `irq_n` is 1.
- R5: Bit 0 of `dlt` sets when an accepted K1 differs from the K1 value accepted before it. Bit 1 does the same for the K2 nibble. Re-accepting the value already held sets neither bit. The accepted values reset to zero, so accepting zero first sets no bit.
- R6: `k1_unstable` rises on the twelfth consecutive strobed frame in which K1 has no run of three. Bit 2 of `dlt` sets on that same edge.
- R7: `k1_unstable` clears, and its frame count restarts, on the edge of any frame that completes a K1 run of three or more.
- R8: A cycle with `clr_wr` high clears every `dlt` bit whose `clr_bits` bit is 1. If a bit sets in the same cycle that it is cleared, it stays set.
- R9: A `dlt_mask` bit of 1 keeps the matching `dlt` bit out of the interrupt. It does not prevent that `dlt` bit from setting.
- R10: `irq_n` is 0 in exactly the cycles in which some `dlt` bit is 1 and its mask bit is 0. It follows `dlt` and `dlt_mask` with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_vld | input | 1 | One-cycle strobe: a new frame's K bytes are valid |
| k1_byte | input | 8 | Received K1 byte |
| k2_hi | input | 4 | Received K2 bits 7 to 4 |
| k2_need | input | 4 | Consecutive equal frames required for the K2 nibble (0 acts as 1) |
| clr_wr | input | 1 | Write strobe for clearing delta bits |
| clr_bits | input | 3 | Delta bits to clear when `clr_wr` is high |
| dlt_mask | input | 3 | Interrupt mask per delta bit |
| k1_acc | output | 8 | Accepted K1 |
| k2_acc | output | 4 | Accepted K2 nibble |
| dlt | output | 3 | Sticky deltas: bit 0 K1 change, bit 1 K2 change, bit 2 K1 instability |
| k1_unstable | output | 1 | K1 instability status |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Accepted values, delta bits and the instability flag are registered. Each one changes on the edge that samples the qualifying frame or clear write, and is due one clock after its stimulus is applied. `irq_n` follows the registered deltas and the mask combinationally, so it moves in the same cycle as `dlt` and immediately when the mask changes. The bench drives inputs on the falling edge and steps its queue-based reference model on the following rising edge. It then compares every output at the next falling edge, so each result is checked in the cycle it is due and in every cycle around it.

// File: rtl/aps_pkg.sv
`timescale 1ns/1ps
package aps_pkg;
    localparam int DLT_W   = 3;
    localparam int DLT_K1  = 0;
    localparam int DLT_K2  = 1;
    localparam int DLT_UNS = 2;
    typedef logic [DLT_W-1:0] dlt_vec_t;
endpackage

// File: rtl/aps_run_filter.sv
`timescale 1ns/1ps
// Persistence filter for one overhead field: counts consecutive equal
// strobed samples and latches the field once the run reaches the threshold.
module aps_run_filter #(
    parameter int W     = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [W-1:0]     din,
    input  logic [CNT_W-1:0] thresh,
    output logic [W-1:0]     acc,
    output logic             hit,
    output logic             changed
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    typedef struct packed {
        logic [W-1:0]     prev;
        logic [CNT_W-1:0] run;
        logic             seen;
        logic [W-1:0]     acc;
    } st_t;

    st_t s_q, s_d;
    logic [CNT_W-1:0] need;

    always_comb begin
        need    = (thresh == '0) ? RUN_ONE : thresh;
        s_d     = s_q;
        hit     = 1'b0;
        changed = 1'b0;
        if (strobe) begin
            s_d.prev = din;
            s_d.seen = 1'b1;
            if (s_q.seen && (din == s_q.prev)) begin
                s_d.run = (s_q.run == RUN_MAX) ? RUN_MAX : s_q.run + 1'b1;
            end else begin
                s_d.run = RUN_ONE;
            end
            if (s_d.run >= need) begin
                hit     = 1'b1;
                changed = (din != s_q.acc);
                s_d.acc = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc = s_q.acc;

    // R3: accepted value only moves on a strobed frame
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(s_q.acc));
    // R3: a differing frame restarts the run at one
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && s_q.seen && (din != s_q.prev)) |=> (s_q.run == RUN_ONE));
    // R1/R2: a qualifying frame is latched
    a_r1_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hit) |=> (s_q.acc == $past(din)));
endmodule

// File: rtl/aps_unstab_mon.sv
`timescale 1ns/1ps
// Counts strobed frames without a qualifying K1 run; flags instability.
module aps_unstab_mon #(
    parameter int LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic hit,
    output logic unstable,
    output logic rise
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (strobe) begin
            if (hit) begin
                s_d.cnt  = '0;
                s_d.flag = 1'b0;
            end else begin
                if (s_q.cnt != CNT_TOP) s_d.cnt = s_q.cnt + 1'b1;
                if (s_d.cnt == CNT_TOP) s_d.flag = 1'b1;
            end
        end
        rise = s_d.flag & ~s_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign unstable = s_q.flag;

    // R7: a qualifying K1 run clears instability
    a_r7_clear_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hit) |=> !s_q.flag);
    // R6: the frame that completes the window raises the flag
    a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !hit && (s_q.cnt == CNT_TOP - 1'b1)) |=> s_q.flag);
endmodule

// File: rtl/aps_event_reg.sv
`timescale 1ns/1ps
// Sticky write-one-to-clear delta bits with mask and active-low interrupt.
module aps_event_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] delta,
    output logic         irq_n
);
    typedef struct packed {
        logic [N-1:0] dlt;
    } st_t;

    st_t s_q, s_d;
    logic [N-1:0] nxt;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb nxt[i] = set[i] | (s_q.dlt[i] & ~(clr_wr & clr_bits[i]));
    end

    always_comb begin
        s_d     = s_q;
        s_d.dlt = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign delta = s_q.dlt;
    assign irq_n = ~|(s_q.dlt & ~mask);

    // R8: a set always lands, even against a same-cycle clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((s_q.dlt & $past(set)) == $past(set)));
    // R8: a clear write removes the bits not being set
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((s_q.dlt & $past(clr_bits & ~set)) == '0));
    // R10: no pending delta means no interrupt
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.dlt == '0) |-> irq_n);
    // R9: fully masked means no interrupt
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> irq_n);
endmodule

// File: rtl/aps_filter_top.sv
`timescale 1ns/1ps
module aps_filter_top
    import aps_pkg::*;
#(
    parameter int K1_PERSIST    = 3,
    parameter int UNSTAB_FRAMES = 12,
    parameter int CNT_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  logic [7:0]       k1_byte,
    input  logic [3:0]       k2_hi,
    input  logic [CNT_W-1:0] k2_need,
    input  logic             clr_wr,
    input  logic [DLT_W-1:0] clr_bits,
    input  logic [DLT_W-1:0] dlt_mask,
    output logic [7:0]       k1_acc,
    output logic [3:0]       k2_acc,
    output logic [DLT_W-1:0] dlt,
    output logic             k1_unstable,
    output logic             irq_n
);
    localparam logic [CNT_W-1:0] K1_NEED = CNT_W'(K1_PERSIST);

    logic     k1_hit, k1_chg, k2_hit, k2_chg, uns_rise;
    dlt_vec_t set_v;

    aps_run_filter #(.W(8), .CNT_W(CNT_W)) u_k1 (
        .clk(clk), .rst_n(rst_n), .strobe(frame_vld), .din(k1_byte),
        .thresh(K1_NEED), .acc(k1_acc), .hit(k1_hit), .changed(k1_chg));

    aps_run_filter #(.W(4), .CNT_W(CNT_W)) u_k2 (
        .clk(clk), .rst_n(rst_n), .strobe(frame_vld), .din(k2_hi),
        .thresh(k2_need), .acc(k2_acc), .hit(k2_hit), .changed(k2_chg));

    aps_unstab_mon #(.LIMIT(UNSTAB_FRAMES)) u_uns (
        .clk(clk), .rst_n(rst_n), .strobe(frame_vld), .hit(k1_hit),
        .unstable(k1_unstable), .rise(uns_rise));

    always_comb begin
        set_v          = '0;
        set_v[DLT_K1]  = k1_chg;
        set_v[DLT_K2]  = k2_chg;
        set_v[DLT_UNS] = uns_rise;
    end

    aps_event_reg #(.N(DLT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr_wr(clr_wr),
        .clr_bits(clr_bits), .mask(dlt_mask), .delta(dlt), .irq_n(irq_n));

    // R5: a K1 delta only appears after a strobed frame
    a_r5_k1_delta_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!dlt[DLT_K1] && !frame_vld) |=> !dlt[DLT_K1]);
    // R2: the K2 nibble never moves without a frame
    a_r2_k2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(k2_acc));
endmodule

// File: tb/aps_filter_top_test.sv
`timescale 1ns/1ps
module aps_filter_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [7:0] k1_byte = '0;
    logic [3:0] k2_hi = '0;
    logic [3:0] k2_need = 4'd3;
    logic       clr_wr = 1'b0;
    logic [2:0] clr_bits = '0;
    logic [2:0] dlt_mask = '0;
    logic [7:0] k1_acc;
    logic [3:0] k2_acc;
    logic [2:0] dlt;
    logic       k1_unstable;
    logic       irq_n;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model state
    logic [7:0] hist1[$];
    logic [3:0] hist2[$];
    logic [7:0] m_k1 = '0;
    logic [3:0] m_k2 = '0;
    logic [2:0] m_dlt = '0;
    int         m_since = 0;
    bit         m_uns = 0;

    always #2 clk = ~clk;

    aps_filter_top uut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .k1_byte(k1_byte),
        .k2_hi(k2_hi), .k2_need(k2_need), .clr_wr(clr_wr), .clr_bits(clr_bits),
        .dlt_mask(dlt_mask), .k1_acc(k1_acc), .k2_acc(k2_acc), .dlt(dlt),
        .k1_unstable(k1_unstable), .irq_n(irq_n));

    function automatic bit tail_equal8(int n);
        if (hist1.size() < n) return 0;
        for (int i = hist1.size() - n; i < hist1.size(); i++)
            if (hist1[i] != hist1[hist1.size()-1]) return 0;
        return 1;
    endfunction

    function automatic bit tail_equal4(int n);
        if (hist2.size() < n) return 0;
        for (int i = hist2.size() - n; i < hist2.size(); i++)
            if (hist2[i] != hist2[hist2.size()-1]) return 0;
        return 1;
    endfunction

    task automatic model_edge();
        logic [2:0] setv = '0;
        if (frame_vld) begin
            int need2 = (k2_need == 0) ? 1 : int'(k2_need);
            hist1.push_back(k1_byte);
            hist2.push_back(k2_hi);
            if (hist1.size() > 15) void'(hist1.pop_front());
            if (hist2.size() > 15) void'(hist2.pop_front());
            if (tail_equal8(3)) begin
                if (k1_byte != m_k1) setv[0] = 1;
                m_k1 = k1_byte;
                m_since = 0;
                m_uns = 0;
            end else begin
                if (m_since < 12) m_since++;
                if (m_since >= 12 && !m_uns) begin
                    m_uns = 1;
                    setv[2] = 1;
                end
            end
            if (tail_equal4(need2)) begin
                if (k2_hi != m_k2) setv[1] = 1;
                m_k2 = k2_hi;
            end
        end
        m_dlt = setv | (m_dlt & ~(clr_wr ? clr_bits : 3'b000));
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        bit m_irq_n = ((m_dlt & ~dlt_mask) == 3'b000);
        cmp(tag, "k1_acc", int'(k1_acc), int'(m_k1));
        cmp(tag, "k2_acc", int'(k2_acc), int'(m_k2));
        cmp(tag, "dlt", int'(dlt), int'(m_dlt));
        cmp(tag, "k1_unstable", int'(k1_unstable), int'(m_uns));
        cmp(tag, "irq_n", int'(irq_n), int'(m_irq_n));
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(bit fv, logic [7:0] k1, logic [3:0] k2, bit cw, logic [2:0] cb, string tag);
        frame_vld = fv; k1_byte = k1; k2_hi = k2; clr_wr = cw; clr_bits = cb;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        frame_vld = 0; clr_wr = 0; clr_bits = '0;
        check_all(tag);
    endtask

    task automatic frame(logic [7:0] k1, logic [3:0] k2, string tag);
        step(1, k1, k2, 0, 3'b000, tag);
    endtask

    task automatic idle(string tag);
        step(0, k1_byte, k2_hi, 0, 3'b000, tag);
    endtask

    task automatic clear(logic [2:0] b, string tag);
        step(0, k1_byte, k2_hi, 1, b, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R4");
        rst_n = 1;
        @(negedge clk);
        check_all("R4");

        // R1: third identical K1 frame is accepted, earlier ones are not
        frame(8'h5A, 4'h0, "R1");
        frame(8'h5A, 4'h0, "R1");
        frame(8'h5A, 4'h0, "R1");
        idle("R10");
        // R8: write-one-to-clear
        clear(3'b001, "R8");

        // R3: idle cycles between frames do not break a run
        frame(8'h77, 4'h0, "R3");
        idle("R3");
        frame(8'h77, 4'h0, "R3");
        idle("R3");
        idle("R3");
        frame(8'h77, 4'h0, "R3");
        clear(3'b111, "R8");
        // R3: a differing frame restarts the run
        frame(8'h10, 4'h0, "R3");
        frame(8'h10, 4'h0, "R3");
        frame(8'h20, 4'h0, "R3");
        frame(8'h10, 4'h0, "R3");
        frame(8'h10, 4'h0, "R3");
        frame(8'h10, 4'h0, "R3");
        clear(3'b111, "R8");

        // R5: re-accepting the held value sets no delta
        for (int i = 0; i < 4; i++) frame(8'h10, 4'h0, "R5");

        // R2: programmable K2 run length
        k2_need = 4'd5;
        for (int i = 0; i < 6; i++) frame(8'h10, 4'hC, "R2");
        clear(3'b010, "R8");
        k2_need = 4'd0;
        frame(8'h10, 4'h3, "R2");
        frame(8'h10, 4'h6, "R2");
        k2_need = 4'd15;
        for (int i = 0; i < 17; i++) frame(8'h10, 4'h9, "R2");
        k2_need = 4'd3;
        clear(3'b111, "R8");

        // R9: masked delta still sets, interrupt stays high
        dlt_mask = 3'b001;
        for (int i = 0; i < 3; i++) frame(8'h44, 4'h9, "R9");
        idle("R9");
        dlt_mask = 3'b000;
        idle("R10");
        clear(3'b001, "R8");

        // R8: set and clear in the same cycle, set wins
        frame(8'h55, 4'h9, "R8");
        frame(8'h55, 4'h9, "R8");
        step(1, 8'h55, 4'h9, 1, 3'b001, "R8");
        clear(3'b001, "R8");

        // R6: alternating K1 never settles
        for (int i = 0; i < 14; i++) frame((i % 2) ? 8'h22 : 8'h11, 4'h9, "R6");
        dlt_mask = 3'b011;
        idle("R9");
        dlt_mask = 3'b000;

        // R7: a settled K1 clears instability
        for (int i = 0; i < 3; i++) frame(8'h33, 4'h9, "R7");
        clear(3'b111, "R8");
        // instability returns after another full window
        for (int i = 0; i < 12; i++) frame(8'h60 + 8'(i), 4'h9, "R6");
        for (int i = 0; i < 3; i++) frame(8'h00, 4'h9, "R7");
        idle("R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule